// File: doc/BRIEF.md
# SPI Interrupt Status Controller

This block gathers the event conditions of an SPI controller into one five-bit raw interrupt vector. It gates that vector with a software mask to produce a masked vector and a single interrupt line. Two of the raw bits are level comparisons of the FIFO fill counts against programmable thresholds, and they follow the levels in every cycle. The other three are sticky error flags. Each error flag is set by an illegal push or pop and is removed only through a clear write.

The surrounding controller supplies the FIFO fill levels, the thresholds, the push and pop strobes and a busy flag. It receives the raw, masked and live status words. The FIFOs and the serial shifter are outside this block. The live status word reports busy and the full and empty state of both FIFOs as plain combinational flags.

Top module: `spi_irq_status`

## Requirements
- R1: After reset the three sticky bits (raw bits 1, 2, 3) are 0, the mask register is 0 and `irq` is 0.
- R2: Raw bit 0 is 1 in the same cycle in which `tx_level <= tx_thresh`, and 0 otherwise.
- R3: Raw bit 4 is 1 in the same cycle in which `rx_level > rx_thresh`, and 0 otherwise.
- R4: Raw bit 1 (transmit overflow) becomes 1 on the cycle after `tx_push` is sampled while `tx_level == DEPTH`. It then holds until it is cleared. A push while the FIFO is not full does not set it.
- R5: Raw bit 2 (receive underflow) becomes 1 on the cycle after `rx_pop` is sampled while `rx_level == 0`, and it is sticky.
- R6: Raw bit 3 (receive overflow) becomes 1 on the cycle after `rx_push` is sampled while `rx_level == DEPTH`, and it is sticky.
- R7: A clear write (`clr_wr`) with `clr_data` bit 3 set clears raw bit 1, with bit 2 set clears raw bit 3, and with bit 1 set clears raw bit 2. The cleared bit reads 0 from the next cycle, and the other sticky bits are unchanged.
- R8: A clear write with `clr_data` bit 0 set clears all three sticky bits on the next cycle.
- R9: When a set condition and a clear of the same sticky bit are sampled in the same cycle, the bit is 1 afterwards.
- R10: A mask write (`mask_wr`) loads `mask_data` into `mask_q` for the next cycle. `masked_stat` equals raw AND mask, and `irq` is the OR of `masked_stat`.
- R11: `live_stat` carries busy in bit 0, transmit full in bit 1, transmit empty in bit 2, receive empty in bit 3 and receive full in bit 4. Full means level equals `DEPTH` and empty means level equals 0.
- R12: Clear writes have no effect on raw bits 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level | input | LW | Transmit FIFO fill count |
| rx_level | input | LW | Receive FIFO fill count |
| tx_thresh | input | LW | Transmit low-water threshold |
| rx_thresh | input | LW | Receive high-water threshold |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| rx_push | input | 1 | Write strobe into the receive FIFO |
| rx_pop | input | 1 | Read strobe from the receive FIFO |
| busy | input | 1 | Serial engine busy flag |
| mask_wr | input | 1 | Mask register write enable |
| mask_data | input | 5 | Mask write data |
| clr_wr | input | 1 | Clear register write enable |
| clr_data | input | 4 | Clear write data |
| raw_stat | output | 5 | Raw interrupt status |
| mask_q | output | 5 | Current mask register |
| masked_stat | output | 5 | Raw status AND mask |
| irq | output | 1 | Combined interrupt |
| live_stat | output | 5 | Live busy and FIFO flags |

## Verification
Some properties are checked on every cycle by the assertions. A sticky bit holds its value when it has neither a set nor a clear. A simultaneous set and clear leaves the bit at 1. A clear without a set drops the bit. A zero mask never raises the interrupt. The transmit full and empty flags are never 1 together. A receive threshold event never occurs while the receive FIFO is empty. Other behaviour only the bench scenarios can show. This includes the exact threshold boundaries (equal and off-by-one levels) and the mapping of each clear bit to its event. It also covers the clear-all bit and the fact that the clears leave the level-derived bits untouched.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int RAW_TXTHR = 0;
  localparam int RAW_TXOVF = 1;
  localparam int RAW_RXUNF = 2;
  localparam int RAW_RXOVF = 3;
  localparam int RAW_RXTHR = 4;
  localparam int NUM_STICKY = 3;

  // sticky index: 0 = tx overflow, 1 = rx underflow, 2 = rx overflow
  function automatic logic [NUM_STICKY-1:0] clr_decode(input logic [3:0] c);
    logic [NUM_STICKY-1:0] r;
    r[0] = c[0] | c[3];
    r[1] = c[0] | c[1];
    r[2] = c[0] | c[2];
    return r;
  endfunction

  function automatic logic lvl_at_or_below(input int unsigned lvl, input int unsigned thr);
    return lvl <= thr;
  endfunction

  function automatic logic lvl_above(input int unsigned lvl, input int unsigned thr);
    return lvl > thr;
  endfunction
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/irq_level_events.sv
module irq_level_events #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_thresh,
  input  logic [LW-1:0] rx_thresh,
  output logic          tx_thr_evt,
  output logic          rx_thr_evt,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          rx_empty
);
  import spi_irq_pkg::*;
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  always_comb begin
    tx_thr_evt = lvl_at_or_below(int'(tx_level), int'(tx_thresh));
    rx_thr_evt = lvl_above(int'(rx_level), int'(rx_thresh));
    tx_full    = (tx_level == FULL_LVL);
    tx_empty   = (tx_level == '0);
    rx_full    = (rx_level == FULL_LVL);
    rx_empty   = (rx_level == '0);
  end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int NB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [NB-1:0] wdata_i,
  input  logic [NB-1:0] raw_i,
  output logic [NB-1:0] mask_o,
  output logic [NB-1:0] masked_o,
  output logic          irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end

  assign masked_o = raw_i & mask_o;
  assign irq_o    = |masked_o;

  assert_mask_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_o == $past(wdata_i)));
  assert_zero_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == '0) |-> !irq_o);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int NB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_thresh,
  input  logic [LW-1:0] rx_thresh,
  input  logic          tx_push,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          busy,
  input  logic          mask_wr,
  input  logic [NB-1:0] mask_data,
  input  logic          clr_wr,
  input  logic [3:0]    clr_data,
  output logic [NB-1:0] raw_stat,
  output logic [NB-1:0] mask_q,
  output logic [NB-1:0] masked_stat,
  output logic          irq,
  output logic [NB-1:0] live_stat
);
  import spi_irq_pkg::*;

  logic tx_thr_evt, rx_thr_evt, tx_full, tx_empty, rx_full, rx_empty;
  logic [NUM_STICKY-1:0] sticky_set, sticky_clr, sticky_q;

  irq_level_events #(.DEPTH(DEPTH)) u_lvl (
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .tx_thr_evt(tx_thr_evt), .rx_thr_evt(rx_thr_evt),
    .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty)
  );

  // named event wires, one per sticky source
  logic ev_tx_ovf, ev_rx_unf, ev_rx_ovf;
  assign ev_tx_ovf = tx_push & tx_full;
  assign ev_rx_unf = rx_pop  & rx_empty;
  assign ev_rx_ovf = rx_push & rx_full;

  assign sticky_set = {ev_rx_ovf, ev_rx_unf, ev_tx_ovf};
  assign sticky_clr = clr_wr ? clr_decode(clr_data) : '0;

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    irq_sticky_bit u_bit (
      .clk(clk), .rst_n(rst_n),
      .set_i(sticky_set[i]), .clr_i(sticky_clr[i]),
      .q_o(sticky_q[i])
    );
  end

  always_comb begin
    raw_stat            = '0;
    raw_stat[RAW_TXTHR] = tx_thr_evt;
    raw_stat[RAW_TXOVF] = sticky_q[0];
    raw_stat[RAW_RXUNF] = sticky_q[1];
    raw_stat[RAW_RXOVF] = sticky_q[2];
    raw_stat[RAW_RXTHR] = rx_thr_evt;
  end

  assign live_stat = {rx_full, rx_empty, tx_empty, tx_full, busy};

  irq_mask_gate #(.NB(NB)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .wr_i(mask_wr), .wdata_i(mask_data),
    .raw_i(raw_stat),
    .mask_o(mask_q), .masked_o(masked_stat), .irq_o(irq)
  );

  assert_tx_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(live_stat[1] && live_stat[2]));
  assert_rxthr_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    raw_stat[RAW_RXTHR] |-> !live_stat[3]);
endmodule

// File: tb/sim_spi_irq_status.sv
module sim_spi_irq_status;
  localparam int DEPTH = 32;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [LW-1:0] tx_level = 5, rx_level = 0, tx_thresh = 4, rx_thresh = 4;
  logic tx_push = 0, rx_push = 0, rx_pop = 0, busy = 0;
  logic mask_wr = 0, clr_wr = 0;
  logic [4:0] mask_data = 0;
  logic [3:0] clr_data = 0;
  logic [4:0] raw_stat, mask_q, masked_stat, live_stat;
  logic irq;

  always #4 clk = ~clk;

  spi_irq_status #(.DEPTH(DEPTH)) u0 (.*);

  typedef struct { string tag; logic [4:0] raw, msk, live; logic irq; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic m_txovf = 0, m_rxunf = 0, m_rxovf = 0;
  logic [4:0] m_mask = 0;

  task automatic expect_now(string tag);
    exp_t e;
    e.tag  = tag;
    e.raw  = {rx_level > rx_thresh, m_rxovf, m_rxunf, m_txovf, tx_level <= tx_thresh};
    e.msk  = e.raw & m_mask;
    e.irq  = (e.msk != 0);
    e.live = {rx_level == DEPTH, rx_level == 0, tx_level == 0, tx_level == DEPTH, busy};
    q.push_back(e);
    #1;
  endtask

  // one clock: model updates at the edge, strobes drop at the falling edge
  task automatic tick();
    @(posedge clk);
    if (tx_push && tx_level == DEPTH) m_txovf = 1;
    else if (clr_wr && (clr_data[0] || clr_data[3])) m_txovf = 0;
    if (rx_pop && rx_level == 0) m_rxunf = 1;
    else if (clr_wr && (clr_data[0] || clr_data[1])) m_rxunf = 0;
    if (rx_push && rx_level == DEPTH) m_rxovf = 1;
    else if (clr_wr && (clr_data[0] || clr_data[2])) m_rxovf = 0;
    if (mask_wr) m_mask = mask_data;
    @(negedge clk);
    tx_push = 0; rx_push = 0; rx_pop = 0; mask_wr = 0; clr_wr = 0;
  endtask

  // monitor: compares each expected item against the ports
  initial forever begin
    exp_t e;
    wait (q.size() > 0);
    e = q.pop_front();
    checks++;
    if (raw_stat !== e.raw || masked_stat !== e.msk || irq !== e.irq || live_stat !== e.live) begin
      errors++;
      $display("FAIL %s: raw=%b masked=%b irq=%b live=%b expected raw=%b masked=%b irq=%b live=%b",
               e.tag, raw_stat, masked_stat, irq, live_stat, e.raw, e.msk, e.irq, e.live);
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_now("R1 reset");
    checks++;
    if (mask_q !== 5'd0) begin errors++; $display("FAIL R1: mask_q=%b expected 00000", mask_q); end

    // R2 tx threshold boundaries
    tx_level = 4; expect_now("R2 equal");
    tx_level = 3; expect_now("R2 below");
    tx_level = 5; expect_now("R2 above");
    tx_level = 0; expect_now("R11 tx empty");

    // R3 rx threshold boundaries
    rx_level = 4; expect_now("R3 equal");
    rx_level = 5; expect_now("R3 above");

    // R10 mask
    mask_data = 5'h1F; mask_wr = 1; tick(); expect_now("R10 all on");
    checks++;
    if (mask_q !== 5'h1F) begin errors++; $display("FAIL R10: mask_q=%b expected 11111", mask_q); end
    mask_data = 5'h02; mask_wr = 1; tick(); expect_now("R10 ovf only");

    // R4 tx overflow
    tx_level = 20; tx_push = 1; tick(); expect_now("R4 push not full");
    tx_level = DEPTH; tx_push = 1; tick(); expect_now("R4 set");
    tick(); tick(); expect_now("R4 sticky hold");
    expect_now("R11 tx full");

    // R5 rx underflow
    rx_level = 3; rx_pop = 1; tick(); expect_now("R5 pop not empty");
    rx_level = 0; rx_pop = 1; tick(); expect_now("R5 set");

    // R6 rx overflow
    rx_level = DEPTH; rx_push = 1; tick(); expect_now("R6 set");
    busy = 1; expect_now("R11 busy and rx full");

    // R7 individual clears
    mask_data = 5'h1F; mask_wr = 1; tick();
    clr_data = 4'b1000; clr_wr = 1; tick(); expect_now("R7 clear tx ovf");
    clr_data = 4'b0100; clr_wr = 1; tick(); expect_now("R7 clear rx ovf");
    clr_data = 4'b0010; clr_wr = 1; tick(); expect_now("R7 clear rx unf");

    // R8 clear all
    tx_push = 1; rx_push = 1; tick();
    rx_level = 0; rx_pop = 1; tick(); expect_now("R8 all set");
    clr_data = 4'b0001; clr_wr = 1; tick(); expect_now("R8 clear all");

    // R9 set wins
    tx_push = 1; clr_data = 4'b1001; clr_wr = 1; tick(); expect_now("R9 set wins");
    checks++;
    if (raw_stat[1] !== 1'b1) begin errors++; $display("FAIL R9: raw1=%b expected 1", raw_stat[1]); end

    // R12 clear leaves threshold bits
    tx_level = 2; rx_level = 9; busy = 0;
    clr_data = 4'b1111; clr_wr = 1; tick(); expect_now("R12 threshold kept");
    checks++;
    if (raw_stat[0] !== 1'b1 || raw_stat[4] !== 1'b1) begin
      errors++; $display("FAIL R12: raw=%b expected bits 0 and 4 set", raw_stat);
    end

    mask_data = 5'h00; mask_wr = 1; tick(); expect_now("R10 mask off");
    #10;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule